// File: doc/BRIEF.md
# Sequential Radix-2 Booth Signed Multiplier

This block multiplies two signed two's complement operands of a configurable width and returns the full double-width signed product. It does the work over several clock cycles on one shared adder. At each step it looks at two bits: the low bit of the multiplier register and the bit shifted out of that register on the step before. From that pair it adds the multiplicand into a running accumulator, subtracts it, or leaves the accumulator alone. It then shifts the whole accumulator/multiplier chain right by one place, copying the sign bit down.

A request is made by pulsing `start` while the block is idle. The operands are captured on that edge. `busy` stays high for exactly `WIDTH` cycles. After that, `done` pulses for one cycle and the product is valid on `product`. The product stays there until the next accepted request. A `start` that arrives while a multiply is running has no effect.

Top module: `booth_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is low captures both operands, and `busy` is high from the next cycle.
- R3: `busy` stays high for exactly `WIDTH` cycles after the accepting edge. In the cycle that follows, `done` is high for one cycle only and `busy` is low. `busy` and `done` are never high together.
- R4: When `done` is high, `product` equals the signed product of the captured operands as a 2·`WIDTH`-bit two's complement value. Operands are read as two's complement: the top bit has weight −2^(WIDTH−1).
- R5: A `start` pulse while `busy` is high is ignored. The product and the `done` timing of the running operation are unchanged, and the new operands are never used.
- R6: While the block is idle, `product` holds its last value, whatever happens on the operand inputs.
- R7: The most negative operand is handled correctly as multiplicand, as multiplier, or as both. For `WIDTH`=5, −16 × −16 = +256 (0x100) and −16 × −1 = +16.
- R8: A pair of 01 (low bit 0, previous bit 1) adds the multiplicand, and a pair of 10 subtracts it. Pairs 00 and 11 only shift. As a result, an all-ones multiplier (−1) gives the negated multiplicand and a zero multiplier gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; only acted on while idle |
| multiplicand | input | WIDTH | Signed multiplicand, captured on accepted start |
| multiplier | input | WIDTH | Signed multiplier, captured on accepted start |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
An accumulator that is too narrow, a wrong add/subtract choice, or a logical shift where an arithmetic one is needed all show up as a wrong `product` in the `done` cycle. Such faults are exposed only by operands whose bit patterns start the affected pair, so the bench covers every operand pair at width 5. A stale previous bit, a counter off by one, or a restart taken while busy shows at the ports within one operation: as a shifted `done` pulse, as a `busy` cycle count other than `WIDTH`, or as a product that mixes in the second operand set.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear accumulator and previous bit
    logic step;   // one add/subtract/skip plus arithmetic shift
  } dpCtrl_t;

  typedef enum logic [1:0] {
    OP_SKIP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } boothOp_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic     lowBit,
  input  logic     prevBit,
  output boothOp_e op
);

  always_comb begin
    unique case ({lowBit, prevBit})
      2'b01:   op = OP_ADD;   // end of a run of ones
      2'b10:   op = OP_SUB;   // start of a run of ones
      default: op = OP_SKIP;  // inside a run of zeros or ones
    endcase
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output dpCtrl_t ctrl,
  output logic    busy,
  output logic    done
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e        state;
  logic [CW-1:0] stepCnt;
  logic          doneReg;

  always_comb begin
    ctrl.load = (state == ST_IDLE) && start;
    ctrl.step = (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST) begin
            state   <= ST_IDLE;
            doneReg <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_RUN);
  assign done = doneReg;

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            ctrl,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product
);

  localparam int AW = WIDTH + 1;  // one guard bit on the accumulator

  logic [AW-1:0]    acc;
  logic [WIDTH-1:0] qReg;
  logic             qPrev;
  logic [WIDTH-1:0] mcand;

  boothOp_e         op;
  logic [AW-1:0]    mExt;
  logic [AW-1:0]    addend;
  logic [AW-1:0]    sum;

  booth_recode u_recode (
    .lowBit (qReg[0]),
    .prevBit(qPrev),
    .op     (op)
  );

  always_comb begin
    mExt = {mcand[WIDTH-1], mcand};
    unique case (op)
      OP_ADD:  addend = mExt;
      OP_SUB:  addend = ~mExt + AW'(1);
      default: addend = '0;
    endcase
    sum = acc + addend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc   <= '0;
      qReg  <= '0;
      qPrev <= 1'b0;
      mcand <= '0;
    end else if (ctrl.load) begin
      acc   <= '0;
      qReg  <= multiplier;
      qPrev <= 1'b0;
      mcand <= multiplicand;
    end else if (ctrl.step) begin
      acc   <= {sum[AW-1], sum[AW-1:1]};
      qReg  <= {sum[0], qReg[WIDTH-1:1]};
      qPrev <= qReg[0];
    end
  end

  assign product = {acc[WIDTH-1:0], qReg};

endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  dpCtrl_t ctrl;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctrl (ctrl),
    .busy (busy),
    .done (done)
  );

  booth_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .multiplicand(multiplicand),
    .multiplier  (multiplier),
    .product     (product)
  );

endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);

  localparam int CW = $clog2(WIDTH + 2);

  // Cycles spent busy since the last accepted request
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                runCnt <= '0;
    else if (start && !busy)  runCnt <= '0;
    else if (busy)            runCnt <= runCnt + 1'b1;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runCnt == CW'(WIDTH)));

  // R5
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && (runCnt < CW'(WIDTH - 1))) |=> (busy && !done));

  // R6
  product_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product));

endmodule

bind booth_mult booth_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .product(product)
);

// File: tb/booth_mult_test.sv
module booth_mult_test;

  localparam int W  = 5;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  mcandIn = '0;
  logic [W-1:0]  mplierIn = '0;
  logic          busy;
  logic          done;
  logic [PW-1:0] product;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  booth_mult #(.WIDTH(W)) uut (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .multiplicand(mcandIn),
    .multiplier  (mplierIn),
    .busy        (busy),
    .done        (done),
    .product     (product)
  );

  function automatic int sx(logic [W-1:0] v);
    return v[W-1] ? int'(v) - (1 << W) : int'(v);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Run one multiply; optionally pulse start again mid-run with other operands.
  task automatic runMul(logic [W-1:0] a, logic [W-1:0] b, bit poke, string req);
    int expVal;
    int cyc;
    logic [PW-1:0] expBits;
    expVal  = sx(a) * sx(b);
    expBits = expVal[PW-1:0];
    @(negedge clk);
    mcandIn = a; mplierIn = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mcandIn = ~a; mplierIn = b + 1'b1;
    cyc = 1;
    if (poke) begin
      // R5: second start while busy
      @(negedge clk);
      start = 1'b1;
      cyc++;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    while (!done && cyc < 4 * W) begin
      if (!busy && !done) break;
      @(negedge clk);
      if (!done) cyc++;
    end
    // R3: done after exactly W busy cycles
    check(done == 1'b1 && cyc == W, req, "done latency", cyc, W);
    // R4 / R7 / R8: product value
    check(product == expBits, req, "product", int'(product), int'(expBits));
    check(busy == 1'b0, req, "busy at done", int'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R3", "done width", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1", "busy", int'(busy), 0);
    check(done == 1'b0, "R1", "done", int'(done), 0);
    check(product == '0, "R1", "product", int'(product), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: busy follows an accepted start
    mcandIn = 5'd3; mplierIn = 5'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    while (busy) @(negedge clk);
    check(product == PW'(21), "R4", "3*7", int'(product), 21);

    // R7: most negative operands
    runMul(5'b10000, 5'b10000, 1'b0, "R7");
    runMul(5'b10000, 5'b11111, 1'b0, "R7");
    runMul(5'b11111, 5'b10000, 1'b0, "R7");
    runMul(5'b01111, 5'b10000, 1'b0, "R7");

    // R8: all-ones and zero multipliers
    runMul(5'd9, 5'b11111, 1'b0, "R8");
    runMul(5'b10110, 5'd0, 1'b0, "R8");
    runMul(5'b01010, 5'b01010, 1'b0, "R8");

    // R5: start while busy is ignored
    runMul(5'b10101, 5'b01101, 1'b1, "R5");
    runMul(5'd6, 5'b11011, 1'b1, "R5");

    // R6: product holds while idle with changing operands
    begin
      logic [PW-1:0] held;
      held = product;
      for (int k = 0; k < 6; k++) begin
        mcandIn = W'(k * 7);
        mplierIn = W'(k * 3 + 1);
        @(negedge clk);
      end
      check(product == held, "R6", "held product", int'(product), int'(held));
    end

    // R4: exhaustive sweep of every operand pair
    for (int i = 0; i < (1 << W); i++) begin
      for (int j = 0; j < (1 << W); j++) begin
        runMul(i[W-1:0], j[W-1:0], 1'b0, "R4");
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule